// File: doc/BRIEF.md
# Byte Shifter for a Shared Two-Wire Bus

This block moves one byte at a time across a two-wire, open-drain bus that several masters can share. Software first sets the bus enable bit in the control register. Each write to the data register then loads a byte. The block presents that byte most significant bit first through an open-drain data driver. The same shifter collects the bits that appear on the wired data line, so at the end of the byte the data register holds what the bus actually carried. The acknowledge bit, the start and stop conditions and address matching belong to software, which handles them through general-purpose pins.

The block never drives the clock line. It counts only clock edges it observes. A slow partner that holds the clock low therefore simply delays the next bit. The clock input passes through a synchronizer and then a level filter, so a pulse narrower than a set number of internal cycles is not taken as an edge. When the block drives a 1 but the line reads back 0, it records lost arbitration and releases its driver. It keeps receiving until the byte ends.

Clearing the bus enable bit stops a transfer at once and raises the end-of-transfer interrupt. A normal byte completion raises the same interrupt.

Top module: `twb_shifter`

## Requirements
- R1: After reset, `sda_oe` and `eot_irq` are 0, and `ctrl_q` and `data_q` read 0.
- R2: A data write (`wr_sel`=1) while bus enable (control bit 0) is set starts a transfer, most significant bit first. `sda_oe` is 1 exactly when the bit being sent is 0. The next bit appears only after a falling clock edge that follows the rising edge which sampled the current bit.
- R3: The data line is sampled on each rising edge of the filtered clock. On the 8th rising edge the block releases its driver, loads the received byte into `data_q` (first sampled bit in bit 7), sets the done bit (control bit 1) and pulses `eot_irq` for one cycle.
- R4: The bit count advances only on observed rising clock edges. A low phase of any length adds no bit.
- R5: A change of the clock input that lasts fewer than FILT_CYC internal cycles (default 2) is ignored.
- R6: If a bit the block sends as 1 is sampled as 0, control bit 5 is set. `sda_oe` then stays 0 for the rest of the byte, and the received byte still reflects the line.
- R7: A data write clears control bit 5 and the done bit, and re-enables the driver.
- R8: Writing control bit 0 from 1 to 0 aborts the transfer. It releases the driver, leaves done clear and pulses `eot_irq` in the same cycle. Later clock edges complete nothing.
- R9: A data write while bus enable is clear stores the value in `data_q` without starting a transfer. `sda_oe` stays 0 and clock pulses set no done bit.
- R10: A clock pulse after a completed byte (the acknowledge slot) changes neither `data_q`, nor the done bit, nor `sda_oe`, nor `eot_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control, 1 selects data |
| wr_data | input | DATA_W | Write value; bit 0 is bus enable for control writes |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| eot_irq | output | 1 | One-cycle end-of-transfer interrupt |
| ctrl_q | output | 8 | Control: bit 0 enable, bit 1 done, bit 5 arbitration lost |
| data_q | output | DATA_W | Data register |

## Verification
A change on `scl_in` acts inside the shifter at the 5th rising clock edge after it is driven (two synchronizer stages, two filter cycles, one edge register). Register writes act at the next edge. The bench therefore holds each clock phase for at least 8 cycles and samples every result on the falling clock edge, well after the edge that produces it. The driver state is read 4 or more cycles into a low phase, after the shift has settled. Completion, arbitration and `eot_irq` are checked once the high phase has ended, and interrupts are counted on every falling edge so that any extra or missing pulse is caught.

// File: rtl/twb_pkg.sv
package twb_pkg;
   localparam int CTRL_W        = 8;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_DONE_BIT = 1;
   localparam int CTRL_ARB_BIT  = 5;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DATA = 1'b1
   } twb_sel_e;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/twb_glitch_filter.sv
module twb_glitch_filter #(
   parameter int FILT_CYC = 2,
   parameter bit RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic level,
   output logic rise,
   output logic fall
);
   logic level_d;

   generate
      if (FILT_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level <= RST_VAL;
            else        level <= d;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYC);
         logic [CW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= RST_VAL;
               run   <= '0;
            end else if (d == level) begin
               run <= '0;
            end else if (run == CW'(FILT_CYC - 1)) begin
               level <= d;
               run   <= '0;
            end else begin
               run <= run + CW'(1);
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= RST_VAL;
      else        level_d <= level;
   end

   assign rise = level & ~level_d;
   assign fall = ~level & level_d;
endmodule

// File: rtl/twb_shift_core.sv
module twb_shift_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              enable,
   input  logic              abort,
   input  logic [DATA_W-1:0] load_data,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   output logic              busy,
   output logic              arb_lost,
   output logic              done_pulse,
   output logic              drive_low,
   output logic [DATA_W-1:0] rx_data
);
   localparam int CNT_W = $clog2(DATA_W);

   logic [DATA_W-1:0] shreg;
   logic [CNT_W-1:0]  bit_cnt;
   logic              rx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         bit_cnt    <= '0;
         rx_bit     <= 1'b0;
         busy       <= 1'b0;
         arb_lost   <= 1'b0;
         done_pulse <= 1'b0;
         rx_data    <= '0;
      end else begin
         done_pulse <= 1'b0;
         if (data_wr) begin
            arb_lost <= 1'b0;
            if (enable) begin
               shreg   <= load_data;
               bit_cnt <= '0;
               busy    <= 1'b1;
            end
         end else if (abort) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
         end else if (busy) begin
            if (scl_rise) begin
               rx_bit <= sda_s;
               if (shreg[DATA_W-1] && !sda_s) arb_lost <= 1'b1;
               if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                  busy       <= 1'b0;
                  done_pulse <= 1'b1;
                  bit_cnt    <= '0;
                  rx_data    <= {shreg[DATA_W-2:0], sda_s};
               end else begin
                  bit_cnt <= bit_cnt + CNT_W'(1);
               end
            end else if (scl_fall && bit_cnt != '0) begin
               shreg <= {shreg[DATA_W-2:0], rx_bit};
            end
         end
      end
   end

   assign drive_low = busy & ~arb_lost & ~shreg[DATA_W-1];
endmodule

// File: rtl/twb_shifter.sv
module twb_shifter #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   output logic              eot_irq,
   output logic [7:0]        ctrl_q,
   output logic [DATA_W-1:0] data_q
);
   import twb_pkg::*;

   generate
      if (DATA_W < 2)      begin : g_bad_width  $error("DATA_W must be at least 2");      end
      if (SYNC_STAGES < 2) begin : g_bad_sync   $error("SYNC_STAGES must be at least 2"); end
      if (FILT_CYC < 1)    begin : g_bad_filter $error("FILT_CYC must be at least 1");    end
   endgenerate

   logic scl_s, sda_s, scl_lvl, scl_rise, scl_fall;
   logic bus_en, done_q, core_busy, core_arb, core_done;
   logic [DATA_W-1:0] core_rx;
   logic ctrl_wr, data_wr, abort;

   assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
   assign data_wr = wr_en && (wr_sel == SEL_DATA);
   assign abort   = ctrl_wr && bus_en && !wr_data[0];

   twb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));

   twb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   twb_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .d(scl_s),
      .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

   twb_shift_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .enable(bus_en),
      .abort(abort), .load_data(wr_data), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .sda_s(sda_s), .busy(core_busy),
      .arb_lost(core_arb), .done_pulse(core_done), .drive_low(sda_oe),
      .rx_data(core_rx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_en  <= 1'b0;
         done_q  <= 1'b0;
         eot_irq <= 1'b0;
         data_q  <= '0;
      end else begin
         eot_irq <= 1'b0;
         if (ctrl_wr) begin
            bus_en <= wr_data[0];
            if (abort) eot_irq <= 1'b1;
         end
         if (data_wr) begin
            data_q <= wr_data;
            done_q <= 1'b0;
         end else if (core_done) begin
            data_q  <= core_rx;
            done_q  <= 1'b1;
            eot_irq <= 1'b1;
         end
      end
   end

   always_comb begin
      ctrl_q                = '0;
      ctrl_q[CTRL_EN_BIT]   = bus_en;
      ctrl_q[CTRL_DONE_BIT] = done_q;
      ctrl_q[CTRL_ARB_BIT]  = core_arb;
   end
endmodule

// File: rtl/twb_shifter_chk.sv
module twb_shifter_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic wr_sel,
   input logic sda_oe,
   input logic eot_irq,
   input logic ctl_en,
   input logic ctl_done,
   input logic ctl_arb,
   input logic busy,
   input logic scl_lvl
);
   assert_arb_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_arb |-> !sda_oe);

   assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_oe);

   assert_done_eot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_done) |-> eot_irq);

   assert_abort_eot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_en) |-> eot_irq);

   assert_steady_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl) && busy && $past(busy) && !$past(wr_en)) |-> $stable(sda_oe));

   assert_write_clears_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && wr_sel) |-> !ctl_arb);
endmodule

bind twb_shifter twb_shifter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .sda_oe(sda_oe), .eot_irq(eot_irq),
   .ctl_en(ctrl_q[0]), .ctl_done(ctrl_q[1]), .ctl_arb(ctrl_q[5]),
   .busy(core_busy), .scl_lvl(scl_lvl));

// File: tb/twb_shifter_bench.sv
module twb_shifter_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       scl_in = 1'b1;
   logic       other_bit = 1'b1;
   logic       sda_oe, eot_irq, sda_in;
   logic [7:0] ctrl_q, data_q;

   int n_chk = 0;
   int n_err = 0;
   int eot_cnt = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_in = ~sda_oe & other_bit;

   twb_shifter u_twb_shifter (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .scl_in(scl_in), .sda_in(sda_in),
      .sda_oe(sda_oe), .eot_irq(eot_irq), .ctrl_q(ctrl_q), .data_q(data_q));

   always @(negedge clk) if (rst_n && eot_irq) eot_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic sel, input logic [7:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
      wait_n(2);
   endtask

   // one clock pulse; returns driver state seen late in the low phase
   task automatic pulse(input logic ob, input int low_extra, input bit spike, output logic oe_seen);
      other_bit = ob;
      wait_n(4);
      if (spike) begin
         scl_in = 1'b1; @(negedge clk); scl_in = 1'b0; wait_n(3);
      end
      wait_n(low_extra);
      oe_seen = sda_oe;
      scl_in = 1'b1;
      wait_n(8);
      if (spike) begin
         scl_in = 1'b0; @(negedge clk); scl_in = 1'b1; wait_n(3);
      end
      scl_in = 1'b0;
      wait_n(8);
      other_bit = 1'b1;
   endtask

   task automatic xfer(input logic [7:0] tx, input logic [7:0] other, input int low_extra, input bit spike, input string req);
      logic [7:0] rx;
      logic arb, drv, line, oe;
      int eot0;
      arb = 0;
      reg_wr(1'b1, tx);
      chk(ctrl_q[5] == 1'b0 && ctrl_q[1] == 1'b0, "R7", ctrl_q, ctrl_q & 8'hDD);
      eot0 = eot_cnt;
      for (int i = 7; i >= 0; i--) begin
         drv  = arb ? 1'b1 : tx[i];
         line = drv & other[i];
         pulse(other[i], low_extra, spike, oe);
         chk(oe == !drv, req, oe, !drv);
         if (drv && !line) arb = 1;
         rx[i] = line;
      end
      chk(data_q == rx, req, data_q, rx);
      chk(ctrl_q[1] == 1'b1 && ctrl_q[5] == arb, "R3/R6", ctrl_q, {2'b0, arb, 3'b0, 1'b1, 1'b1});
      chk(eot_cnt == eot0 + 1 && sda_oe == 1'b0, "R3", eot_cnt - eot0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic oe;
      int eot0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      chk(sda_oe == 0 && eot_irq == 0, "R1", {sda_oe, eot_irq}, 0);
      chk(ctrl_q == 0 && data_q == 0, "R1", {ctrl_q, data_q}, 0);
      scl_in = 1'b0;
      wait_n(10);

      // R9: data write with bus disabled stores only
      eot0 = eot_cnt;
      reg_wr(1'b1, 8'h5A);
      chk(data_q == 8'h5A && sda_oe == 0, "R9", data_q, 8'h5A);
      for (int i = 0; i < 8; i++) pulse(1'b1, 0, 0, oe);
      chk(ctrl_q[1] == 0 && eot_cnt == eot0 && data_q == 8'h5A, "R9", ctrl_q, 0);

      reg_wr(1'b0, 8'h01);
      chk(ctrl_q == 8'h01, "R2", ctrl_q, 8'h01);

      // R2/R3: every byte value against an idle partner
      for (int v = 0; v < 256; v++) xfer(8'(v), 8'hFF, 0, 0, "R2");

      // R10: acknowledge slot pulse has no effect
      eot0 = eot_cnt;
      pulse(1'b0, 0, 0, oe);
      chk(oe == 0 && data_q == 8'hFF && ctrl_q[1] == 1 && eot_cnt == eot0, "R10", data_q, 8'hFF);

      // R4: stretched low phases
      xfer(8'hA5, 8'hFF, 60, 0, "R4");
      xfer(8'h3C, 8'hFF, 150, 0, "R4");

      // R5: narrow spikes on both phases
      xfer(8'h96, 8'hFF, 0, 1, "R5");
      xfer(8'h0F, 8'hFF, 5, 1, "R5");

      // R6/R7: contested bytes
      for (int k = 0; k < 12; k++) xfer(8'(k * 37 + 200), 8'(k * 91 + 5), 0, 0, "R6");
      xfer(8'hFF, 8'h00, 0, 0, "R6");
      reg_wr(1'b1, 8'h00);
      chk(ctrl_q[5] == 0, "R7", ctrl_q, 0);
      xfer(8'h81, 8'hFF, 0, 0, "R7");

      // R8: abort mid-byte
      reg_wr(1'b1, 8'h00);
      for (int i = 0; i < 3; i++) pulse(1'b1, 0, 0, oe);
      chk(sda_oe == 1, "R8", sda_oe, 1);
      eot0 = eot_cnt;
      reg_wr(1'b0, 8'h00);
      chk(sda_oe == 0 && eot_cnt == eot0 + 1 && ctrl_q[1] == 0, "R8", eot_cnt - eot0, 1);
      reg_wr(1'b0, 8'h01);
      for (int i = 0; i < 8; i++) pulse(1'b1, 0, 0, oe);
      chk(ctrl_q[1] == 0 && eot_cnt == eot0 + 1 && sda_oe == 0, "R8", ctrl_q, 8'h01);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule